// File: doc/BRIEF.md
# SPI Register-Access Slave

This block is the serial front end of a radio controller's register file. An external master drives an SPI bus in mode 0, most significant bit first. Each frame opens with a header byte: a read/write flag, a burst flag and a six-bit address. The block holds the configuration registers itself and shows their contents on a flat output bus. It reads read-only status values from a flat input bus and turns command addresses into single-cycle strobe pulses.

While a header byte is shifted in, the slave returns a live status byte. It returns the same byte while each write data byte is shifted in. The status byte packs the not-ready flag, the radio state code and a FIFO fill count. For a read the count is the number of receive FIFO bytes available. For a write it is the free space in the transmit FIFO. A burst flag on a configuration address enables auto-increment until chip select rises. In the command range the same flag chooses between a one-shot status-register read and a command strobe.

All bus inputs are synchronised into the system clock domain. SCLK therefore has to be slow relative to `clk`: each SCLK phase must last at least four `clk` cycles.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, `so` and `so_oe` are 0, every `cmd_strobe` bit is 0 and every configuration register (`cfg_flat`) reads 0x00; `so` stays 0 whenever `csn` is high.
- R2: While a header byte is shifted in, `so` returns the status byte {`chip_rdy_n`, `main_state[2:0]`, count[3:0]}. The count comes from `rx_count` when header bit 7 is 1 (read) and from `tx_space` when it is 0 (write). Header bit 6 is the burst flag and bits 5:0 are the address.
- R3: The 4-bit count field reports the input value when it is below 15 and reports 15 for any value of 15 or more.
- R4: A write header (bit 7 = 0) to an address in 0x00..0x2E, followed by a data byte, stores that byte in the addressed register at `cfg_flat[8*addr +: 8]`. The write-form status byte is returned during the data byte.
- R5: A read header (bit 7 = 1, bit 6 = 0) to 0x00..0x2E returns the register value in the following byte. Without the burst flag, the byte after that is decoded as a new header.
- R6: With the burst flag set on 0x00..0x2F, the address advances by one after every data byte, for reads and writes alike. It stops advancing once it reaches 0x2E.
- R7: A read header with the burst flag set on 0x30..0x3D returns `stat_flat[8*(addr-0x30) +: 8]` in the next byte, and the byte after that is a new header. A write with the burst flag set in that range changes no register and fires no strobe.
- R8: A header with the burst flag clear on 0x30..0x3D, read or write, raises `cmd_strobe[addr-0x30]` for exactly one `clk` cycle and no other strobe bit. The next byte is a new header.
- R9: Addresses 0x2F, 0x3E and 0x3F read as 0x00, and writes to them change no register.
- R10: Raising `csn` in the middle of a byte discards that byte and commits nothing. The next frame starts with a header byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock from the master (mode 0) |
| csn | input | 1 | SPI chip select, active low |
| si | input | 1 | Serial data from the master |
| so | output | 1 | Serial data to the master, 0 when idle |
| so_oe | output | 1 | High while the slave is selected and driving `so` |
| chip_rdy_n | input | 1 | Not-ready flag placed in status bit 7 |
| main_state | input | 3 | Radio state code placed in status bits 6:4 |
| rx_count | input | CNT_W | Bytes available in the receive FIFO |
| tx_space | input | CNT_W | Free bytes in the transmit FIFO |
| stat_flat | input | 8*NUM_STAT | Read-only status registers, index k at address 0x30+k |
| cfg_flat | output | 8*NUM_CFG | Contents of the configuration registers |
| cmd_strobe | output | NUM_STAT | One-cycle command pulses, index k for address 0x30+k |

## Verification
The hardest states to reach are the ones a well-behaved master never creates. One is a frame cut off part-way through a byte, either in the header or in a data byte. Another is a burst that runs past the top of the configuration range, where the address must stop at 0x2E. The bench bit-bangs the bus itself, so it can raise chip select after any number of bits. A later full frame then shows whether a partial write leaked in or whether the header decoder stayed out of step. The saturating address is reached by starting a four-byte burst write at 0x2C. Reading the same range back shows the last two bytes landing in one register.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

    localparam int ADDR_W      = 6;
    localparam int BYTE_W      = 8;
    localparam int STAT_BASE_I = 48;   // first address of the command / status range
    localparam int FIFO_FIELD  = 4;

    typedef enum logic [1:0] {
        PH_HDR   = 2'd0,
        PH_WDATA = 2'd1,
        PH_RDATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic              rd;
        logic              burst;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    typedef struct packed {
        logic                  rdy_n;
        logic [2:0]            state;
        logic [FIFO_FIELD-1:0] fill;
    } status_t;

    function automatic logic [FIFO_FIELD-1:0] fill_clamp(input logic [15:0] n);
        return (n > 16'd15) ? 4'hF : n[FIFO_FIELD-1:0];
    endfunction

    function automatic logic addr_between(input logic [ADDR_W-1:0] a, input int lo, input int hi);
        return ({26'd0, a} >= lo) && ({26'd0, a} <= hi);
    endfunction

endpackage

// File: rtl/spi_level_sync.sv
module spi_level_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_s,
    input  logic              csn_s,
    input  logic              si_s,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              active,
    output logic              first_bit,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              so_bit
);
    logic        sclk_q;
    logic [2:0]  bit_cnt;
    logic [2:0]  out_idx;
    logic [6:0]  shift_in;
    logic        rise, fall;

    assign active = ~csn_s;
    assign rise   = active & sclk_s & ~sclk_q;
    assign fall   = active & ~sclk_s & sclk_q;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            bit_cnt  <= '0;
            out_idx  <= '0;
            shift_in <= '0;
        end else begin
            if (rise) begin
                shift_in <= {shift_in[5:0], si_s};
                bit_cnt  <= bit_cnt + 3'd1;
            end
            if (fall) out_idx <= bit_cnt;
        end
    end

    assign first_bit = rise && (bit_cnt == 3'd0);
    assign byte_done = rise && (bit_cnt == 3'd7);
    assign rx_byte   = {shift_in, si_s};
    assign so_bit    = tx_byte[3'd7 - out_idx];

    // R10
    abort_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(csn_s) |=> (bit_cnt == 3'd0));
endmodule

// File: rtl/spi_txn_ctrl.sv
module spi_txn_ctrl
    import spi_reg_pkg::*;
#(
    parameter int NUM_CFG  = 47,
    parameter int NUM_STAT = 14,
    parameter int CNT_W    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              first_bit,
    input  logic              si_s,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              chip_rdy_n,
    input  logic [2:0]        main_state,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_space,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [NUM_STAT-1:0] cmd_strobe
);
    localparam int LAST_CFG_I = NUM_CFG - 1;
    localparam int STAT_END_I = STAT_BASE_I + NUM_STAT - 1;
    localparam logic [ADDR_W-1:0] LAST_CFG = ADDR_W'(LAST_CFG_I);

    phase_e            phase;
    logic [ADDR_W-1:0] addr_q;
    logic              burst_q;
    logic              hdr_rd;
    logic [BYTE_W-1:0] data_q;
    logic [NUM_STAT-1:0] strobe_q;

    hdr_t              hdr;
    status_t           stat_now;
    logic              hdr_cmd;
    logic              hdr_stat;
    logic              dir_rd;
    logic [ADDR_W-1:0] adv_addr;

    assign hdr      = hdr_t'(rx_byte);
    assign hdr_stat = addr_between(hdr.addr, STAT_BASE_I, STAT_END_I);
    assign hdr_cmd  = hdr_stat && !hdr.burst;
    assign adv_addr = (addr_q < LAST_CFG) ? addr_q + 1'b1 : addr_q;
    assign rd_addr  = (phase == PH_HDR) ? hdr.addr : adv_addr;

    assign dir_rd         = (phase == PH_HDR) ? hdr_rd : (phase == PH_RDATA);
    assign stat_now.rdy_n = chip_rdy_n;
    assign stat_now.state = main_state;
    assign stat_now.fill  = dir_rd ? fill_clamp(16'(rx_count)) : fill_clamp(16'(tx_space));
    assign tx_byte        = (phase == PH_RDATA) ? data_q : BYTE_W'(stat_now);

    assign wr_en   = byte_done && (phase == PH_WDATA) && ({26'd0, addr_q} <= LAST_CFG_I);
    assign wr_addr = addr_q;
    assign wr_data = rx_byte;
    assign cmd_strobe = strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_HDR;
            addr_q   <= '0;
            burst_q  <= 1'b0;
            hdr_rd   <= 1'b0;
            data_q   <= '0;
            strobe_q <= '0;
        end else begin
            strobe_q <= '0;
            if (!active) begin
                phase <= PH_HDR;
            end else begin
                if (first_bit && phase == PH_HDR) hdr_rd <= si_s;
                if (byte_done) begin
                    unique case (phase)
                        PH_HDR: begin
                            if (hdr_cmd) begin
                                for (int k = 0; k < NUM_STAT; k++)
                                    if (hdr.addr == ADDR_W'(STAT_BASE_I + k)) strobe_q[k] <= 1'b1;
                            end else begin
                                addr_q  <= hdr.addr;
                                burst_q <= hdr.burst && !hdr_stat;
                                phase   <= hdr.rd ? PH_RDATA : PH_WDATA;
                                if (hdr.rd) data_q <= rd_data;
                            end
                        end
                        PH_WDATA: begin
                            if (burst_q) addr_q <= adv_addr;
                            else         phase  <= PH_HDR;
                        end
                        PH_RDATA: begin
                            if (burst_q) begin
                                addr_q <= adv_addr;
                                data_q <= rd_data;
                            end else begin
                                phase <= PH_HDR;
                            end
                        end
                        default: phase <= PH_HDR;
                    endcase
                end
            end
        end
    end

    // R8
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_strobe));

    // R8
    strobe_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_strobe != '0) |-> $past(byte_done));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(addr_q) == LAST_CFG && $past(phase) != PH_HDR && phase != PH_HDR)
        |-> addr_q == LAST_CFG);

    // R7
    single_read_end_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_done && phase == PH_RDATA && !burst_q) |=> phase == PH_HDR);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_reg_pkg::*;
#(
    parameter int NUM_CFG  = 47,
    parameter int NUM_STAT = 14
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [BYTE_W*NUM_STAT-1:0] stat_flat,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [BYTE_W*NUM_CFG-1:0]  cfg_flat
);
    logic [BYTE_W-1:0] mem [NUM_CFG];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CFG; i++) begin
            if (rst)                                    mem[i] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(i))    mem[i] <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_flat
        assign cfg_flat[g*BYTE_W +: BYTE_W] = mem[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CFG; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = mem[i];
        for (int k = 0; k < NUM_STAT; k++)
            if (rd_addr == ADDR_W'(STAT_BASE_I + k)) rd_data = stat_flat[k*BYTE_W +: BYTE_W];
    end

    // R9
    write_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ({26'd0, wr_addr} < NUM_CFG));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_reg_pkg::*;
#(
    parameter int NUM_CFG     = 47,
    parameter int NUM_STAT    = 14,
    parameter int CNT_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sclk,
    input  logic                       csn,
    input  logic                       si,
    output logic                       so,
    output logic                       so_oe,
    input  logic                       chip_rdy_n,
    input  logic [2:0]                 main_state,
    input  logic [CNT_W-1:0]           rx_count,
    input  logic [CNT_W-1:0]           tx_space,
    input  logic [BYTE_W*NUM_STAT-1:0] stat_flat,
    output logic [BYTE_W*NUM_CFG-1:0]  cfg_flat,
    output logic [NUM_STAT-1:0]        cmd_strobe
);
    logic sclk_s, csn_s, si_s;
    logic active, first_bit, byte_done, so_bit;
    logic [BYTE_W-1:0] rx_byte, tx_byte, rd_data, wr_data;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic              wr_en;

    spi_level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst(rst), .din(sclk), .dout(sclk_s));
    spi_level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
        .clk(clk), .rst(rst), .din(csn), .dout(csn_s));
    spi_level_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_si (
        .clk(clk), .rst(rst), .din(si), .dout(si_s));

    spi_bit_engine u_bits (
        .clk(clk), .rst(rst), .sclk_s(sclk_s), .csn_s(csn_s), .si_s(si_s),
        .tx_byte(tx_byte), .active(active), .first_bit(first_bit),
        .byte_done(byte_done), .rx_byte(rx_byte), .so_bit(so_bit));

    spi_txn_ctrl #(.NUM_CFG(NUM_CFG), .NUM_STAT(NUM_STAT), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .active(active), .first_bit(first_bit), .si_s(si_s),
        .byte_done(byte_done), .rx_byte(rx_byte), .chip_rdy_n(chip_rdy_n),
        .main_state(main_state), .rx_count(rx_count), .tx_space(tx_space),
        .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tx_byte(tx_byte), .cmd_strobe(cmd_strobe));

    spi_reg_bank #(.NUM_CFG(NUM_CFG), .NUM_STAT(NUM_STAT)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .stat_flat(stat_flat), .rd_data(rd_data), .cfg_flat(cfg_flat));

    assign so_oe = active;
    assign so    = active & so_bit;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !so_oe |-> (so == 1'b0 && !wr_en));
endmodule

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
    localparam int NUM_CFG  = 47;
    localparam int NUM_STAT = 14;
    localparam int CNT_W    = 7;
    localparam int H        = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1;
    logic sclk = 1'b0, csn = 1'b1, si = 1'b0;
    logic so, so_oe;
    logic chip_rdy_n = 1'b0;
    logic [2:0] main_state = 3'b010;
    logic [CNT_W-1:0] rx_count = 7'd5, tx_space = 7'd40;
    logic [8*NUM_STAT-1:0] stat_flat = '0;
    logic [8*NUM_CFG-1:0]  cfg_flat;
    logic [NUM_STAT-1:0]   cmd_strobe;

    spi_reg_slave #(.NUM_CFG(NUM_CFG), .NUM_STAT(NUM_STAT), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .csn(csn), .si(si), .so(so), .so_oe(so_oe),
        .chip_rdy_n(chip_rdy_n), .main_state(main_state), .rx_count(rx_count),
        .tx_space(tx_space), .stat_flat(stat_flat), .cfg_flat(cfg_flat), .cmd_strobe(cmd_strobe));

    int checks = 0, fails = 0;
    int stb_cnt [NUM_STAT];
    int stb_total = 0;
    int stb_multi = 0;
    bit finished = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if ($countones(cmd_strobe) > 1) stb_multi++;
            for (int k = 0; k < NUM_STAT; k++)
                if (cmd_strobe[k]) begin stb_cnt[k]++; stb_total++; end
        end
    end

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic chki(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] cfg(input int a);
        return cfg_flat[a*8 +: 8];
    endfunction

    task automatic frame_begin();
        @(negedge clk); csn = 1'b0;
    endtask

    task automatic frame_end();
        repeat (H) @(negedge clk);
        csn = 1'b1;
        repeat (2*H) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            si = tx[i];
            repeat (H) @(negedge clk);
            rx[i] = so;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        send_bits(tx, 8, rx);
    endtask

    task automatic t_reset();
        chk8("R1 so idle", {7'd0, so}, 8'h00);
        chk8("R1 so_oe idle", {7'd0, so_oe}, 8'h00);
        chki("R1 strobe idle", int'(cmd_strobe), 0);
        chki("R1 cfg cleared", int'(cfg_flat == '0), 1);
    endtask

    task automatic t_single_write();
        logic [7:0] r;
        frame_begin();
        xbyte(8'h05, r); chk8("R2 write header status", r, 8'h2F);
        xbyte(8'hA5, r); chk8("R4 status during write data", r, 8'h2F);
        frame_end();
        chk8("R4 register 0x05 written", cfg(5), 8'hA5);
        chk8("R1 so idle after frame", {7'd0, so}, 8'h00);
    endtask

    task automatic t_single_read();
        logic [7:0] r;
        frame_begin();
        xbyte(8'h85, r); chk8("R2 read header status", r, 8'h25);
        xbyte(8'h85, r); chk8("R5 read data", r, 8'hA5);
        xbyte(8'h85, r); chk8("R5 next byte is header", r, 8'h25);
        xbyte(8'h00, r); chk8("R5 second read data", r, 8'hA5);
        frame_end();
    endtask

    task automatic t_clamp();
        logic [7:0] r;
        chip_rdy_n = 1'b1; main_state = 3'b110; rx_count = 7'd14; tx_space = 7'd15;
        frame_begin();
        xbyte(8'h85, r); chk8("R3 rx count 14", r, 8'hEE);
        xbyte(8'h00, r);
        xbyte(8'h05, r); chk8("R3 tx space 15", r, 8'hEF);
        xbyte(8'hA5, r);
        frame_end();
        rx_count = 7'd100;
        frame_begin();
        xbyte(8'h85, r); chk8("R3 rx count 100 saturates", r, 8'hEF);
        xbyte(8'h00, r);
        frame_end();
        chip_rdy_n = 1'b0; main_state = 3'b010; rx_count = 7'd5; tx_space = 7'd40;
    endtask

    task automatic t_burst();
        logic [7:0] r;
        frame_begin();
        xbyte(8'h6C, r); chk8("R6 burst write header", r, 8'h2F);
        xbyte(8'h11, r); xbyte(8'h22, r); xbyte(8'h33, r); xbyte(8'h44, r);
        frame_end();
        chk8("R6 burst 0x2C", cfg(8'h2C), 8'h11);
        chk8("R6 burst 0x2D", cfg(8'h2D), 8'h22);
        chk8("R6 burst holds at 0x2E", cfg(8'h2E), 8'h44);
        frame_begin();
        xbyte(8'hEC, r); chk8("R6 burst read header", r, 8'h25);
        xbyte(8'h00, r); chk8("R6 burst read 0x2C", r, 8'h11);
        xbyte(8'h00, r); chk8("R6 burst read 0x2D", r, 8'h22);
        xbyte(8'h00, r); chk8("R6 burst read 0x2E", r, 8'h44);
        xbyte(8'h00, r); chk8("R6 burst read held", r, 8'h44);
        frame_end();
    endtask

    task automatic t_status_regs();
        logic [7:0] r;
        logic [8*NUM_CFG-1:0] snap;
        int tot0;
        stat_flat[4*8 +: 8]  = 8'h5A;
        stat_flat[13*8 +: 8] = 8'hC7;
        frame_begin();
        xbyte(8'hF4, r); chk8("R7 status read header", r, 8'h25);
        xbyte(8'h00, r); chk8("R7 status reg 0x34", r, 8'h5A);
        xbyte(8'hFD, r); chk8("R7 single access then header", r, 8'h25);
        xbyte(8'h00, r); chk8("R7 status reg 0x3D", r, 8'hC7);
        frame_end();
        snap = cfg_flat; tot0 = stb_total;
        frame_begin();
        xbyte(8'h74, r);
        xbyte(8'hFF, r);
        frame_end();
        chki("R7 status write leaves cfg", int'(cfg_flat == snap), 1);
        chki("R7 status write no strobe", stb_total, tot0);
    endtask

    task automatic t_strobe();
        logic [7:0] r;
        frame_begin();
        xbyte(8'h36, r); chk8("R8 strobe header status", r, 8'h2F);
        xbyte(8'h85, r); chk8("R8 next byte is header", r, 8'h25);
        xbyte(8'h00, r); chk8("R8 read after strobe", r, 8'hA5);
        frame_end();
        chki("R8 strobe 6 once", stb_cnt[6], 1);
        chki("R8 single strobe total", stb_total, 1);
        frame_begin();
        xbyte(8'hB6, r); chk8("R8 read-form strobe status", r, 8'h25);
        frame_end();
        chki("R8 read-form strobe 6", stb_cnt[6], 2);
        frame_begin();
        xbyte(8'h3D, r);
        frame_end();
        chki("R8 strobe 13", stb_cnt[13], 1);
        chki("R8 strobe total", stb_total, 3);
        chki("R8 never multi-hot", stb_multi, 0);
    endtask

    task automatic t_unused();
        logic [7:0] r;
        logic [8*NUM_CFG-1:0] snap;
        snap = cfg_flat;
        frame_begin();
        xbyte(8'h2F, r); xbyte(8'h77, r);
        frame_end();
        chki("R9 write 0x2F ignored", int'(cfg_flat == snap), 1);
        frame_begin();
        xbyte(8'hAF, r); chk8("R9 read header 0x2F", r, 8'h25);
        xbyte(8'h00, r); chk8("R9 0x2F reads zero", r, 8'h00);
        frame_end();
        frame_begin();
        xbyte(8'hFE, r);
        xbyte(8'h00, r); chk8("R9 0x3E reads zero", r, 8'h00);
        xbyte(8'h00, r); chk8("R9 0x3E burst stays zero", r, 8'h00);
        frame_end();
        frame_begin();
        xbyte(8'hBF, r);
        xbyte(8'h00, r); chk8("R9 0x3F reads zero", r, 8'h00);
        frame_end();
    endtask

    task automatic t_abort();
        logic [7:0] r;
        frame_begin();
        xbyte(8'h07, r);
        send_bits(8'hC3, 4, r);
        frame_end();
        chk8("R10 partial write dropped", cfg(7), 8'h00);
        frame_begin();
        xbyte(8'h87, r); chk8("R10 header after abort", r, 8'h25);
        xbyte(8'h00, r); chk8("R10 register 0x07 still zero", r, 8'h00);
        frame_end();
        frame_begin();
        send_bits(8'h08, 3, r);
        frame_end();
        frame_begin();
        xbyte(8'h08, r); chk8("R10 header realigned", r, 8'h2F);
        xbyte(8'h3C, r);
        frame_end();
        chk8("R10 write after header abort", cfg(8), 8'h3C);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int k = 0; k < NUM_STAT; k++) stb_cnt[k] = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_single_write();
        t_single_read();
        t_clamp();
        t_burst();
        t_status_regs();
        t_strobe();
        t_unused();
        t_abort();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end
endmodule